// File: doc/BRIEF.md
# Relative Seconds Countdown Alarm

This block is a software-armed alarm that counts down whole seconds. Software writes a seconds count into the load register and sets the run bit. From then on, each pulse of the one-second tick input lowers the count by one. A separate read-only register lets software read the seconds that remain. When the count steps from one to zero, a sticky pending flag sets. The flag then drives an interrupt line if the interrupt-enable bit is set, and a wakeup line if the wakeup-enable bit is set. Software clears the flag by writing a one to the status register.

A three-state machine tracks the countdown:
- **IDLE**: the run bit is clear and the count is held.
- **RUN**: the run bit is set and the count is above zero.
- **DONE**: the run bit is set and the count is zero.

The transitions are:
- **start**: IDLE to RUN, when the run bit is set and the count is non-zero.
- **start_empty**: IDLE to DONE, when the run bit is set and the count is zero. The flag does not set.
- **expire**: RUN to DONE, on the tick that takes the count from 1 to 0. The flag sets.
- **zero_load**: RUN to DONE, when software loads 0. The flag does not set.
- **reload**: DONE to RUN, when software loads a non-zero value.
- **stop**: RUN or DONE to IDLE, when the run bit is cleared.

The register bus uses word addresses and has no wait states. Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `cntdn_alarm`

## Requirements
- R1: After reset, the current count (address 1) reads 0. The run, interrupt-enable and wakeup-enable bits (bit 0 of addresses 2, 3 and 4) read 0. The pending flag (bit 0 of address 5) reads 0. `irq_o` and `wake_o` are low.
- R2: A write to address 0 stores the value, which reads back at address 0. The value is also copied into the current count at address 1 at the same clock edge, whatever the run bit is.
- R3: While the run bit is 1 and the count is above zero, each clock edge that samples `tick_1hz` high lowers the count by exactly one, including from the all-ones value.
- R4: While the run bit is 0, ticks leave the count unchanged.
- R5: The pending flag sets at the edge of the tick that takes the count from 1 to 0, and at no earlier tick.
- R6: Once the count is 0, further ticks neither clear the pending flag nor set it again after software has cleared it.
- R7: Writing a word with bit 0 set to address 5 clears the pending flag. Writing a word with bit 0 clear to address 5 leaves the flag unchanged.
- R8: `irq_o` is high exactly when the pending flag and the interrupt-enable bit (address 3, bit 0) are both 1.
- R9: `wake_o` is high exactly when the pending flag and the wakeup-enable bit (address 4, bit 0) are both 1.
- R10: Loading 0 sets the count to zero without setting the pending flag. A load in the same cycle as a tick wins over the tick.
- R11: Clearing the run bit freezes the count. Setting it again resumes the countdown from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Interrupt: pending flag AND interrupt enable |
| wake_o | output | 1 | Wakeup: pending flag AND wakeup enable |

## Verification
The following properties are checked on every cycle:
- The count moves only through a load or a single-step decrement, and stays frozen while stopped.
- The pending flag rises only when the count is zero, stays sticky until cleared, and drops after a clear.
- Neither output line is ever driven while its enable is low.

Some behaviour only the bench scenarios can show: the exact tick on which the flag appears, for a sweep of load values and all four enable combinations, the absence of a second assertion of the flag while the count rests at zero, and the load-over-tick priority seen through the bus.

// File: rtl/cntdn_pkg.sv
package cntdn_pkg;

    localparam int REG_AW = 3;

    // word addresses of the register map
    localparam logic [REG_AW-1:0] A_LOAD   = 3'd0;
    localparam logic [REG_AW-1:0] A_CUR    = 3'd1;
    localparam logic [REG_AW-1:0] A_RUN    = 3'd2;
    localparam logic [REG_AW-1:0] A_IRQEN  = 3'd3;
    localparam logic [REG_AW-1:0] A_WAKEEN = 3'd4;
    localparam logic [REG_AW-1:0] A_STAT   = 3'd5;

    // number of single-bit control registers starting at A_RUN
    localparam int N_CTL = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cntdn_state_e;

endpackage

// File: rtl/cntdn_regs.sv
module cntdn_regs
    import cntdn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cur_val,
    input  logic              pend,
    output logic              load_we,
    output logic [CNT_W-1:0]  load_val,
    output logic              run_en,
    output logic              irq_en,
    output logic              wake_en,
    output logic              clr_pend,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [CNT_W-1:0] load_q;
    logic             ctl_q [N_CTL];

    assign load_we  = bus_we && (bus_addr == A_LOAD);
    assign load_val = bus_wdata[CNT_W-1:0];
    assign clr_pend = bus_we && (bus_addr == A_STAT) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (load_we) begin
            load_q <= load_val;
        end
    end

    // one flop per control bit, at consecutive addresses from A_RUN
    for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
        localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(int'(A_RUN) + i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[i] <= 1'b0;
            end else if (bus_we && (bus_addr == MY_ADDR)) begin
                ctl_q[i] <= bus_wdata[0];
            end
        end
    end

    assign run_en  = ctl_q[0];
    assign irq_en  = ctl_q[1];
    assign wake_en = ctl_q[2];

    function automatic logic [DATA_W-1:0] zext(input logic [CNT_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CNT_W-1:0] = v;
        return r;
    endfunction

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LOAD:   bus_rdata = zext(load_q);
            A_CUR:    bus_rdata = zext(cur_val);
            A_RUN:    bus_rdata[0] = run_en;
            A_IRQEN:  bus_rdata[0] = irq_en;
            A_WAKEEN: bus_rdata[0] = wake_en;
            A_STAT:   bus_rdata[0] = pend;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cntdn_fsm.sv
module cntdn_fsm
    import cntdn_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output cntdn_state_e     state
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cntdn_state_e     nxt_state;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign count    = cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt_cnt;
        end
    end

    // next state, next count and expiry pulse
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt_q;
        expire    = 1'b0;
        if (load_we) begin
            nxt_cnt = load_val;
        end
        unique case (state)
            ST_IDLE, ST_RUN: begin
                if (!run_en) begin
                    nxt_state = ST_IDLE;                 // stop / hold
                end else if (load_we) begin
                    nxt_state = (load_val == '0) ? ST_DONE : ST_RUN;
                end else if (cnt_zero) begin
                    nxt_state = ST_DONE;                 // start_empty
                end else if (tick) begin
                    nxt_cnt = cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        expire    = 1'b1;                // expire
                        nxt_state = ST_DONE;
                    end else begin
                        nxt_state = ST_RUN;
                    end
                end else begin
                    nxt_state = ST_RUN;                  // start
                end
            end
            ST_DONE: begin
                if (!run_en) begin
                    nxt_state = ST_IDLE;                 // stop
                end else if (load_we && (load_val != '0)) begin
                    nxt_state = ST_RUN;                  // reload
                end else begin
                    nxt_state = ST_DONE;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/cntdn_flag.sv
module cntdn_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_pend,
    input  logic irq_en,
    input  logic wake_en,
    output logic pend,
    output logic irq_o,
    output logic wake_o
);

    // an expiry in the same cycle as a clear wins, so no event is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (clr_pend) begin
            pend <= 1'b0;
        end
    end

    always_comb begin
        irq_o  = pend && irq_en;
        wake_o = pend && wake_en;
    end

endmodule

// File: rtl/cntdn_alarm.sv
module cntdn_alarm
    import cntdn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wake_o
);

    logic             load_we;
    logic [CNT_W-1:0] load_val;
    logic             run_en;
    logic             irq_en;
    logic             wake_en;
    logic             clr_pend;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             pend_q;
    cntdn_state_e     fsm_state;

    cntdn_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_val   (cnt_q),
        .pend      (pend_q),
        .load_we   (load_we),
        .load_val  (load_val),
        .run_en    (run_en),
        .irq_en    (irq_en),
        .wake_en   (wake_en),
        .clr_pend  (clr_pend),
        .bus_rdata (bus_rdata)
    );

    cntdn_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .run_en   (run_en),
        .load_we  (load_we),
        .load_val (load_val),
        .count    (cnt_q),
        .expire   (expire),
        .state    (fsm_state)
    );

    cntdn_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .clr_pend (clr_pend),
        .irq_en   (irq_en),
        .wake_en  (wake_en),
        .pend     (pend_q),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

endmodule

// File: rtl/cntdn_chk.sv
module cntdn_chk
    import cntdn_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             pend,
    input logic             run_en,
    input logic             load_we,
    input logic [CNT_W-1:0] load_val,
    input logic             irq_en,
    input logic             wake_en,
    input logic             irq_o,
    input logic             wake_o,
    input logic             clr,
    input logic             expire,
    input cntdn_state_e     state
);

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count == $past(load_val));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_we && tick && count != '0) |=> count == $past(count) - CNT_W'(1));

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_we) |=> $stable(count));

    // R5
    rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (count == '0 && state == ST_DONE));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !pend);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !pend) |-> !irq_o);

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_en || !pend) |-> !wake_o);

    // R10
    load_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !pend) |=> !pend);

endmodule

bind cntdn_alarm cntdn_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .count    (cnt_q),
    .pend     (pend_q),
    .run_en   (run_en),
    .load_we  (load_we),
    .load_val (load_val),
    .irq_en   (irq_en),
    .wake_en  (wake_en),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .clr      (clr_pend),
    .expire   (expire),
    .state    (fsm_state)
);

// File: tb/sim_cntdn_alarm.sv
`timescale 1ns/1ps
module sim_cntdn_alarm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cntdn_alarm u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write with optional tick in the same cycle
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit with_tick = 1'b0);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick_1hz  = with_tick;
        @(negedge clk);
        bus_we    = 1'b0;
        tick_1hz  = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, d); chk("R1 count", d, 32'd0);
        rd(3'd2, d); chk("R1 run", d, 32'd0);
        rd(3'd3, d); chk("R1 irq_en", d, 32'd0);
        rd(3'd4, d); chk("R1 wake_en", d, 32'd0);
        rd(3'd5, d); chk("R1 pend", d, 32'd0);
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 wake_o", {31'd0, wake_o}, 32'd0);

        // R2 load while stopped
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, d); chk("R2 load readback", d, 32'h1234_5678);
        rd(3'd1, d); chk("R2 count copy", d, 32'h1234_5678);

        // R4 ticks while stopped
        ticks(3);
        rd(3'd1, d); chk("R4 held", d, 32'h1234_5678);
        rd(3'd5, d); chk("R4 no pend", d, 32'd0);

        // sweep of load values and enable combinations
        for (int n = 1; n <= 6; n++) begin
            for (int m = 0; m < 4; m++) begin
                wr(3'd2, 32'd0);
                wr(3'd5, 32'd1);
                wr(3'd0, 32'd0);
                rd(3'd1, d); chk("R10 zero load", d, 32'd0);
                wr(3'd0, n);
                wr(3'd3, {31'd0, m[0]});
                wr(3'd4, {31'd0, m[1]});
                wr(3'd2, 32'd1);
                for (int t = 1; t < n; t++) begin
                    ticks(1);
                    rd(3'd1, d); chk("R3 step", d, n - t);
                    rd(3'd5, d); chk("R5 not early", d, 32'd0);
                end
                ticks(1);
                rd(3'd1, d); chk("R3 reach zero", d, 32'd0);
                rd(3'd5, d); chk("R5 pend set", d, 32'd1);
                chk("R8 irq", {31'd0, irq_o}, {31'd0, m[0]});
                chk("R9 wake", {31'd0, wake_o}, {31'd0, m[1]});
                ticks(2);
                rd(3'd1, d); chk("R6 stays zero", d, 32'd0);
                rd(3'd5, d); chk("R6 sticky", d, 32'd1);
                wr(3'd5, 32'hFFFF_FFFE);
                rd(3'd5, d); chk("R7 write0 ignored", d, 32'd1);
                wr(3'd5, 32'd1);
                rd(3'd5, d); chk("R7 cleared", d, 32'd0);
                chk("R8 irq low after clear", {31'd0, irq_o}, 32'd0);
                chk("R9 wake low after clear", {31'd0, wake_o}, 32'd0);
                ticks(2);
                rd(3'd5, d); chk("R6 no re-raise", d, 32'd0);
            end
        end

        // R11 pause and resume
        wr(3'd0, 32'd10);
        ticks(3);
        rd(3'd1, d); chk("R11 running", d, 32'd7);
        wr(3'd2, 32'd0);
        ticks(2);
        rd(3'd1, d); chk("R11 paused", d, 32'd7);
        wr(3'd2, 32'd1);
        ticks(1);
        rd(3'd1, d); chk("R11 resumed", d, 32'd6);

        // R10 zero load while running, then load colliding with tick
        wr(3'd0, 32'd0);
        rd(3'd1, d); chk("R10 zero while running", d, 32'd0);
        rd(3'd5, d); chk("R10 no pend on zero", d, 32'd0);
        wr(3'd0, 32'd5, 1'b1);
        rd(3'd1, d); chk("R10 load beats tick", d, 32'd5);
        wr(3'd0, 32'd1, 1'b1);
        rd(3'd5, d); chk("R10 no expire on load", d, 32'd0);
        rd(3'd1, d); chk("R10 count after load", d, 32'd1);

        // R3 from all ones
        wr(3'd0, 32'hFFFF_FFFF);
        ticks(1);
        rd(3'd1, d); chk("R3 all ones", d, 32'hFFFF_FFFE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule